// File: doc/BRIEF.md
# Stereo Silence Flag with Noise Test Output

The block watches a stereo sample stream and raises a single status pin once both channels have carried nothing but zero samples for a long, fixed run of frames. Board logic typically uses the pin to switch off an output stage during digital silence. Each frame arrives as a left and a right sample together with a one-cycle strobe. Sample values present while the strobe is low are never looked at.

The same pin also serves as a test signal source. A small write port reaches a test register. While that register holds one particular code, the pin carries the output of a free-running maximal-length shift-register noise generator instead of the silence flag. The generator advances on an external tick that is derived from the sample rate: at 128 times the sample rate with a master clock of 512 times the sample rate, the tick is high on one clock in four. Silence tracking keeps running while the noise source drives the pin.

Top module: `zero_noise_flag`

## Requirements
- R1: In flag mode, `flag_o` is high after the clock edge that samples the 1024th consecutive strobed frame in which both `left_i` and `right_i` are zero. After only 1023 such frames it is still low.
- R2: Clock edges where `frame_vld_i` is low neither count nor clear silence, whatever the values on `left_i` and `right_i`.
- R3: A strobed frame with a nonzero sample on either channel drops `flag_o` after that same edge and restarts the run, so 1024 new all-zero frames are needed before the flag rises again.
- R4: The silence count saturates. `flag_o` stays high for as long as all-zero frames continue, with no wrap-around.
- R5: The test register sits at address 511 of the write port. Writing value 7 there selects the noise source on `flag_o` from the next cycle on. Any other value selects the silence flag. Writes to any other address change nothing.
- R6: The noise generator takes exactly one step for each cycle with `bit_tick_i` high and holds its state otherwise. In noise mode `flag_o` is the most significant bit of the generator state.
- R7: The noise sequence has maximal length: it repeats every 2^LFSR_W - 1 steps, with no shorter period, and contains 2^(LFSR_W-1) ones per period. It never reaches the all-zero state.
- R8: After reset the test register is 0, the silence count is 0 and `flag_o` is low in flag mode.
- R9: Silence counting continues while noise is selected. Switching back to flag mode shows the flag for the silence seen in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_vld_i | input | 1 | One-cycle strobe marking a valid stereo frame |
| left_i | input | SAMPLE_W | Left sample, two's complement |
| right_i | input | SAMPLE_W | Right sample, two's complement |
| bit_tick_i | input | 1 | Noise step enable |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register write address |
| reg_wdata_i | input | DATA_W | Register write data |
| flag_o | output | 1 | Silence flag or noise bit |

## Verification
The bench keeps the default silence limit of 1024 frames. This lets it check the exact 1023/1024 boundary, saturation, and restarts after a nonzero sample on each channel in turn. It builds the noise generator with LFSR_W = 8 instead of 24, so that two full periods of 255 steps fit in a short run. With that width it can confirm the period, reject every shorter period that divides 255, and count the ones per period. These checks use only the maximal-length property, not a copy of the tap set.

// File: rtl/zd_pkg.sv
package zd_pkg;

  // Fibonacci feedback masks for maximal-length sequences, bit i = tap i+1
  function automatic logic [31:0] lfsr_tap_mask(input int unsigned width);
    case (width)
      4:       return 32'h0000_000C;
      8:       return 32'h0000_00B8;
      16:      return 32'h0000_D008;
      24:      return 32'h00E1_0000;
      32:      return 32'h8020_0003;
      default: return 32'h0000_0000;
    endcase
  endfunction

  typedef enum logic {
    SEL_SILENCE = 1'b0,
    SEL_NOISE   = 1'b1
  } out_sel_e;

endpackage

// File: rtl/zd_test_reg.sv
module zd_test_reg #(
  parameter int unsigned ADDR_W     = 9,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned TEST_ADDR  = 511,
  parameter int unsigned NOISE_CODE = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output zd_pkg::out_sel_e  sel_o
);
  localparam logic [ADDR_W-1:0] ADDR_HIT = ADDR_W'(TEST_ADDR);
  localparam logic [DATA_W-1:0] CODE_HIT = DATA_W'(NOISE_CODE);

  logic [DATA_W-1:0] test_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          test_q <= '0;
    else if (we_i && addr_i == ADDR_HIT)  test_q <= wdata_i;
  end

  assign sel_o = (test_q == CODE_HIT) ? zd_pkg::SEL_NOISE : zd_pkg::SEL_SILENCE;
endmodule

// File: rtl/zd_silence_counter.sv
module zd_silence_counter #(
  parameter int unsigned SAMPLE_W       = 24,
  parameter int unsigned SILENCE_FRAMES = 1024,
  localparam int unsigned CNT_W         = $clog2(SILENCE_FRAMES + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frame_vld_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic [CNT_W-1:0]    cnt_o,
  output logic                silent_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SILENCE_FRAMES);

  logic             any_nz;
  logic [CNT_W-1:0] cnt_q;

  assign any_nz = (|left_i) | (|right_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (frame_vld_i) begin
      if (any_nz)              cnt_q <= '0;
      else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o    = cnt_q;
  assign silent_o = (cnt_q == LIMIT);
endmodule

// File: rtl/zd_noise_lfsr.sv
module zd_noise_lfsr #(
  parameter int unsigned       LFSR_W = 24,
  parameter logic [LFSR_W-1:0] SEED   = LFSR_W'(1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  output logic [LFSR_W-1:0] state_o,
  output logic              bit_o
);
  localparam logic [31:0]       MASK32 = zd_pkg::lfsr_tap_mask(LFSR_W);
  localparam logic [LFSR_W-1:0] TAPS   = MASK32[LFSR_W-1:0];

  logic [LFSR_W-1:0] state_q;
  logic              fb;

  generate
    if (LFSR_W < 2 || TAPS == '0) begin : g_bad_width
      initial $error("zd_noise_lfsr: unsupported LFSR_W");
    end
  endgenerate

  assign fb = ^(state_q & TAPS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= SEED;
    else if (step_i) state_q <= {state_q[LFSR_W-2:0], fb};
  end

  assign state_o = state_q;
  assign bit_o   = state_q[LFSR_W-1];
endmodule

// File: rtl/zero_noise_flag.sv
module zero_noise_flag #(
  parameter int unsigned SAMPLE_W       = 24,
  parameter int unsigned SILENCE_FRAMES = 1024,
  parameter int unsigned LFSR_W         = 24,
  parameter int unsigned ADDR_W         = 9,
  parameter int unsigned DATA_W         = 8,
  parameter int unsigned TEST_ADDR      = 511,
  parameter int unsigned NOISE_CODE     = 7,
  localparam int unsigned CNT_W         = $clog2(SILENCE_FRAMES + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frame_vld_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic                bit_tick_i,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic                flag_o
);
  zd_pkg::out_sel_e  out_sel;
  logic [CNT_W-1:0]  silence_cnt;
  logic              silent;
  logic [LFSR_W-1:0] noise_state;
  logic              noise_bit;

  zd_test_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .TEST_ADDR(TEST_ADDR), .NOISE_CODE(NOISE_CODE)
  ) i_test_reg (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .sel_o(out_sel)
  );

  zd_silence_counter #(
    .SAMPLE_W(SAMPLE_W), .SILENCE_FRAMES(SILENCE_FRAMES)
  ) i_silence (
    .clk_i, .rst_ni, .frame_vld_i, .left_i, .right_i,
    .cnt_o(silence_cnt), .silent_o(silent)
  );

  zd_noise_lfsr #(
    .LFSR_W(LFSR_W), .SEED(LFSR_W'(1))
  ) i_noise (
    .clk_i, .rst_ni, .step_i(bit_tick_i),
    .state_o(noise_state), .bit_o(noise_bit)
  );

  assign flag_o = (out_sel == zd_pkg::SEL_NOISE) ? noise_bit : silent;
endmodule

// File: rtl/zero_noise_flag_chk.sv
module zero_noise_flag_chk #(
  parameter int unsigned SILENCE_FRAMES = 1024,
  parameter int unsigned CNT_W          = 11,
  parameter int unsigned LFSR_W         = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_vld_i,
  input logic              any_nz_i,
  input logic              bit_tick_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              silent_i,
  input logic [LFSR_W-1:0] lfsr_i
);
  assert_clear_on_nonzero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_i && any_nz_i |=> cnt_i == '0 && !silent_i);

  assert_no_frame_no_change_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_vld_i |=> $stable(cnt_i));

  assert_rise_on_frame_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(silent_i) |-> $past(frame_vld_i) && !$past(any_nz_i));

  assert_saturate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    silent_i && frame_vld_i && !any_nz_i |=> silent_i);

  assert_noise_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_tick_i |=> $stable(lfsr_i));

  assert_noise_nonzero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_i != '0);

  always_ff @(posedge clk_i)
    if (rst_ni) assert_cnt_bound_R4: assert (cnt_i <= CNT_W'(SILENCE_FRAMES));
endmodule

bind zero_noise_flag zero_noise_flag_chk #(
  .SILENCE_FRAMES(SILENCE_FRAMES), .CNT_W(CNT_W), .LFSR_W(LFSR_W)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .frame_vld_i(frame_vld_i),
  .any_nz_i((|left_i) | (|right_i)), .bit_tick_i(bit_tick_i),
  .cnt_i(silence_cnt), .silent_i(silent), .lfsr_i(noise_state)
);

// File: tb/test_zero_noise_flag.sv
module test_zero_noise_flag;
  localparam int unsigned SW     = 24;
  localparam int unsigned LW     = 8;
  localparam int unsigned PERIOD = (1 << LW) - 1;
  localparam int unsigned NBITS  = 2 * PERIOD;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_vld = 1'b0;
  logic [SW-1:0] left = '0, right = '0;
  logic          tick = 1'b0;
  logic          we = 1'b0;
  logic [8:0]    addr = '0;
  logic [7:0]    wdata = '0;
  logic          flag;

  int checks = 0, fails = 0;
  logic noise_bits [0:NBITS-1];

  always #2 clk = ~clk;

  zero_noise_flag #(.SAMPLE_W(SW), .LFSR_W(LW)) i_zero_noise_flag (
    .clk_i(clk), .rst_ni(rst_n), .frame_vld_i(frame_vld),
    .left_i(left), .right_i(right), .bit_tick_i(tick),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .flag_o(flag)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: flag=%b expected %b", req, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic frame(input logic [SW-1:0] l, input logic [SW-1:0] r);
    @(negedge clk);
    frame_vld = 1'b1; left = l; right = r;
    @(negedge clk);
    frame_vld = 1'b0; left = '0; right = '0;
  endtask

  task automatic zero_frames(input int n);
    for (int i = 0; i < n; i++) frame('0, '0);
  endtask

  task automatic reg_write(input logic [8:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic noise_step();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic t_reset_r8();
    @(negedge clk);
    chk("R8 reset flag", flag, 1'b0);
  endtask

  task automatic t_threshold_r1_r4();
    zero_frames(1023);
    chk("R1 after 1023 zero frames", flag, 1'b0);
    zero_frames(1);
    chk("R1 after 1024 zero frames", flag, 1'b1);
    zero_frames(300);
    chk("R4 saturated after 1324 frames", flag, 1'b1);
  endtask

  task automatic t_nonzero_r3();
    frame(24'h000001, '0);
    chk("R3 left nonzero clears", flag, 1'b0);
    zero_frames(1023);
    chk("R3 restart 1023", flag, 1'b0);
    zero_frames(1);
    chk("R3 restart 1024", flag, 1'b1);
    frame('0, 24'h800000);
    chk("R3 right nonzero clears", flag, 1'b0);
  endtask

  task automatic t_unstrobed_r2();
    zero_frames(1000);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); left = 24'h123456; right = 24'hFFFFFF;
    end
    @(negedge clk); left = '0; right = '0;
    zero_frames(23);
    chk("R2 unstrobed data ignored, 1023", flag, 1'b0);
    zero_frames(1);
    chk("R2 unstrobed data ignored, 1024", flag, 1'b1);
  endtask

  task automatic t_addr_r5();
    reg_write(9'd510, 8'd7);
    chk("R5 write to other address ignored", flag, 1'b1);
    reg_write(9'd511, 8'd6);
    chk("R5 code 6 keeps flag", flag, 1'b1);
  endtask

  task automatic t_noise_r6_r7();
    int mism, ones, per_hits;
    int divs [7] = '{1, 3, 5, 15, 17, 51, 85};
    reg_write(9'd511, 8'd7);
    for (int i = 0; i < NBITS; i++) begin
      noise_step();
      noise_bits[i] = flag;
    end
    mism = 0; ones = 0;
    for (int i = 0; i < int'(PERIOD); i++) begin
      if (noise_bits[i] !== noise_bits[i+PERIOD]) mism++;
      if (noise_bits[i] === 1'b1) ones++;
    end
    chk_int("R7 period 2^W-1 mismatches", mism, 0);
    chk_int("R7 ones per period", ones, 1 << (LW - 1));
    per_hits = 0;
    foreach (divs[k]) begin
      int m = 0;
      for (int i = 0; i < int'(PERIOD); i++)
        if (noise_bits[i] !== noise_bits[i+divs[k]]) m++;
      if (m == 0) per_hits++;
    end
    chk_int("R7 no shorter period", per_hits, 0);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk("R6 held without tick", flag, noise_bits[NBITS-1]);
    end
  endtask

  task automatic t_background_r9();
    frame(24'h000010, '0);
    zero_frames(1024);
    reg_write(9'd511, 8'd3);
    chk("R9 silence tracked during noise", flag, 1'b1);
    reg_write(9'd511, 8'd7);
    frame('0, 24'h000002);
    reg_write(9'd511, 8'd0);
    chk("R9 clear tracked during noise", flag, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_r8();
    t_threshold_r1_r4();
    t_nonzero_r3();
    t_unstrobed_r2();
    t_addr_r5();
    t_noise_r6_r7();
    t_background_r9();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule